// File: doc/BRIEF.md
# Strobe-Gap Watchdog and Reset Sequencer

This block watches a field-device slave for loss of traffic and decides when the slave must be put back into a clean state. Each time the port logic issues a strobe on either the data port or the parameter port, the block restarts a gap timer counted in microsecond ticks. If the gap reaches its limit, it requests a soft reset and lights a steady error indication. The block also watches the data strobe pin itself: a level held low by outside circuitry for long enough is read as a manual reset request, while shorter lows, including the block's own strobes, pass without effect. Reset commands decoded from the bus frame are turned into the same soft-reset request.

A hard reset level follows two digital supply flags. It is held from power-up until the 5 V rail is good and the 24 V rail has climbed past the communication-off level, and it is asserted again whenever the 5 V rail is lost. A hard reset clears the gap timer, the pin-low detector and the blink timer. A soft reset clears none of them. Two LED drives show the slave's state through a fixed priority, with a free-running blink phase for the flashing patterns.

Top module: `comm_wdog_rstctl`

## Requirements
- R1: `hard_rst_o` is 1 while `rst_n` is low and in the clock cycle after any edge that sees `sup5_ok` low. It goes to 0 in the cycle after an edge that sees `sup5_ok` and `sup24_ok` both high, and it stays 0 after that while `sup5_ok` stays high, whatever `sup24_ok` does.
- R2: After a strobe event (`dstb_evt` or `pstb_evt` high at an edge), if WDOG_US ticks pass with no further strobe, `soft_rst_o` is 1 for exactly one cycle, in the cycle after the edge that carries the WDOG_US-th tick.
- R3: The gap timer fires once per silent gap and stays disarmed until the next strobe. A strobe restarts the count from zero. Cycles with `us_tick` low do not advance it.
- R4: A low level on `dstb_pin` seen at RSTLOW_US consecutive ticks gives one `soft_rst_o` pulse in the cycle after the RSTLOW_US-th tick. A shorter low gives none. A continued low gives no further pulse until the pin has been high.
- R5: `cmd_rst_slave` or `cmd_rst_bcast` high at an edge gives `soft_rst_o` = 1 in the next cycle only.
- R6: `soft_rst_o` is never 1 while `hard_rst_o` is 1. A hard reset disarms the gap timer and clears its fired indication.
- R7: A soft reset does not disturb the gap timer count or the blink phase.
- R8: LED drives (1 = lit), in falling priority: reset view (`hard_rst_o`, pin held past the threshold, or `overload`) gives LED1 = 0 and LED2 blinking. `fault_n` = 0 gives LED1 and LED2 blinking in opposite phase. `addr_ok` = 0 gives both blinking in phase. Gap timer fired gives LED1 = 1 and LED2 = 0. Otherwise LED1 = 0 and LED2 = 1.
- R9: The blink phase toggles every BLINK_HALF_US ticks. The default of 200000 gives 2.5 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| dstb_evt | input | 1 | Data-port strobe issued |
| pstb_evt | input | 1 | Parameter-port strobe issued |
| dstb_pin | input | 1 | Sampled data strobe pin level (0 = low) |
| cmd_rst_slave | input | 1 | Addressed reset command pulse |
| cmd_rst_bcast | input | 1 | Broadcast reset command pulse |
| sup5_ok | input | 1 | 5 V rail good flag |
| sup24_ok | input | 1 | 24 V rail above communication-off level |
| overload | input | 1 | 24 V output overloaded or switched off |
| fault_n | input | 1 | Periphery fault, active low |
| addr_ok | input | 1 | Address non-zero and both stored copies agree |
| soft_rst_o | output | 1 | Soft-reset request, one-cycle pulse |
| hard_rst_o | output | 1 | Hard-reset level |
| led1_o | output | 1 | First LED drive, 1 = lit |
| led2_o | output | 1 | Second LED drive, 1 = lit |

## Verification
The hardest states to reach are the ones where two timers run against each other. Examples are a soft reset landing in the middle of a gap count or a blink half-period, and a hard reset arriving while the gap timer is armed. The bench makes these deterministic by holding `us_tick` high so that every cycle is a tick. It then injects the command pulse or drops `sup5_ok` at a chosen cycle offset from a strobe or a blink edge, and measures the intervals that follow to the exact cycle. Timer limits are reduced by parameter so that whole gaps, low periods and blink periods fit in a short run.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  typedef enum logic [2:0] {
    LM_NORMAL,
    LM_WDOG,
    LM_ADDR,
    LM_FAULT,
    LM_RESET
  } led_mode_e;

  // Counter width able to hold values 0 .. lim-1.
  function automatic int unsigned ctr_w(input int unsigned lim);
    return (lim < 3) ? 1 : $clog2(lim);
  endfunction

  // Highest-priority status wins.
  function automatic led_mode_e pick_mode(input logic rst_view,
                                          input logic fault_n,
                                          input logic addr_ok,
                                          input logic wd_fired);
    if (rst_view)      return LM_RESET;
    else if (!fault_n) return LM_FAULT;
    else if (!addr_ok) return LM_ADDR;
    else if (wd_fired) return LM_WDOG;
    else               return LM_NORMAL;
  endfunction

  // Returns {led1, led2}, 1 = lit.
  function automatic logic [1:0] drive_leds(input led_mode_e m, input logic ph);
    case (m)
      LM_RESET: return {1'b0, ph};
      LM_FAULT: return {ph, ~ph};
      LM_ADDR:  return {ph, ph};
      LM_WDOG:  return 2'b10;
      default:  return 2'b01;
    endcase
  endfunction

endpackage

// File: rtl/cwr_supply_rst.sv
module cwr_supply_rst (
  input  logic clk,
  input  logic rst_n,
  input  logic sup5_ok,
  input  logic sup24_ok,
  output logic hard_o,
  output logic hard_d_o
);
  logic hard_q;

  always_comb begin
    if (!sup5_ok)      hard_d_o = 1'b1;
    else if (sup24_ok) hard_d_o = 1'b0;
    else               hard_d_o = hard_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hard_q <= 1'b1;
    else        hard_q <= hard_d_o;
  end

  assign hard_o = hard_q;
endmodule

// File: rtl/cwr_gap_wdog.sv
module cwr_gap_wdog #(
  parameter int unsigned LIMIT = 75000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic strobe,
  output logic fire_o,
  output logic fired_o
);
  localparam int unsigned CW = cwr_pkg::ctr_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          fired_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign fire_o  = armed_q & tick & at_last & ~strobe & ~clr;
  assign fired_o = fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (strobe) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      fired_q <= 1'b0;
    end else if (fire_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b1;
    end else if (armed_q && tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cwr_low_detect.sv
module cwr_low_detect #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic pin,
  output logic fire_o,
  output logic held_o
);
  localparam int unsigned CW = cwr_pkg::ctr_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          held_q;
  logic          pin_low;

  assign pin_low = ~pin;
  assign fire_o  = pin_low & tick & ~held_q & (cnt_q == LAST) & ~clr;
  assign held_o  = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (clr || !pin_low) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (fire_o) begin
      cnt_q  <= '0;
      held_q <= 1'b1;
    end else if (tick && !held_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cwr_blink.sv
module cwr_blink #(
  parameter int unsigned HALF = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic phase_o
);
  localparam int unsigned CW = cwr_pkg::ctr_w(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/comm_wdog_rstctl.sv
module comm_wdog_rstctl #(
  parameter int unsigned WDOG_US       = 75000,
  parameter int unsigned RSTLOW_US     = 100000,
  parameter int unsigned BLINK_HALF_US = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic dstb_evt,
  input  logic pstb_evt,
  input  logic dstb_pin,
  input  logic cmd_rst_slave,
  input  logic cmd_rst_bcast,
  input  logic sup5_ok,
  input  logic sup24_ok,
  input  logic overload,
  input  logic fault_n,
  input  logic addr_ok,
  output logic soft_rst_o,
  output logic hard_rst_o,
  output logic led1_o,
  output logic led2_o
);
  import cwr_pkg::*;

  // Named internal events, visible to the bound checker.
  logic      hard_q;
  logic      hard_d;
  logic      any_strobe;
  logic      wd_fire;
  logic      wd_fired;
  logic      low_fire;
  logic      low_held;
  logic      blink_ph;
  logic      soft_src;
  logic      soft_q;
  logic      rst_view;
  led_mode_e led_mode;
  logic [1:0] led_pair;

  assign any_strobe = dstb_evt | pstb_evt;

  cwr_supply_rst u_sup (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup5_ok  (sup5_ok),
    .sup24_ok (sup24_ok),
    .hard_o   (hard_q),
    .hard_d_o (hard_d)
  );

  cwr_gap_wdog #(.LIMIT(WDOG_US)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hard_q),
    .tick    (us_tick),
    .strobe  (any_strobe),
    .fire_o  (wd_fire),
    .fired_o (wd_fired)
  );

  cwr_low_detect #(.LIMIT(RSTLOW_US)) u_low (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (hard_q),
    .tick   (us_tick),
    .pin    (dstb_pin),
    .fire_o (low_fire),
    .held_o (low_held)
  );

  cwr_blink #(.HALF(BLINK_HALF_US)) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hard_q),
    .tick    (us_tick),
    .phase_o (blink_ph)
  );

  // Soft reset is suppressed whenever a hard reset holds in the next cycle.
  assign soft_src = (wd_fire | low_fire | cmd_rst_slave | cmd_rst_bcast) & ~hard_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= soft_src;
  end

  assign rst_view = hard_q | low_held | overload;
  assign led_mode = pick_mode(rst_view, fault_n, addr_ok, wd_fired);
  assign led_pair = drive_leds(led_mode, blink_ph);

  assign soft_rst_o = soft_q;
  assign hard_rst_o = hard_q;
  assign led1_o     = led_pair[1];
  assign led2_o     = led_pair[0];
endmodule

// File: rtl/cwr_chk.sv
module cwr_chk (
  input logic clk,
  input logic rst_n,
  input logic sup5_ok,
  input logic sup24_ok,
  input logic cmd_rst_slave,
  input logic cmd_rst_bcast,
  input logic overload,
  input logic fault_n,
  input logic soft_rst_o,
  input logic hard_rst_o,
  input logic led1_o,
  input logic led2_o,
  input logic wd_fire,
  input logic low_fire,
  input logic low_held
);
  p_hard_on_loss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sup5_ok |=> hard_rst_o);

  p_hard_wait24_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_rst_o && !sup24_ok) |=> hard_rst_o);

  p_wdog_soft_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fire && sup5_ok) |=> soft_rst_o);

  p_fire_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> !wd_fire);

  p_low_soft_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (low_fire && sup5_ok) |=> soft_rst_o);

  p_cmd_soft_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_rst_slave || cmd_rst_bcast) && sup5_ok && !hard_rst_o) |=> soft_rst_o);

  p_no_soft_hard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_o |-> !soft_rst_o);

  p_led_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overload |-> !led1_o);

  p_led_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !overload && !hard_rst_o && !low_held) |-> (led1_o != led2_o));
endmodule

bind comm_wdog_rstctl cwr_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sup5_ok       (sup5_ok),
  .sup24_ok      (sup24_ok),
  .cmd_rst_slave (cmd_rst_slave),
  .cmd_rst_bcast (cmd_rst_bcast),
  .overload      (overload),
  .fault_n       (fault_n),
  .soft_rst_o    (soft_rst_o),
  .hard_rst_o    (hard_rst_o),
  .led1_o        (led1_o),
  .led2_o        (led2_o),
  .wd_fire       (wd_fire),
  .low_fire      (low_fire),
  .low_held      (low_held)
);

// File: tb/comm_wdog_rstctl_tb.sv
module comm_wdog_rstctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 75;
  localparam int L = 100;
  localparam int H = 20;

  // {overload, fault_n, addr_ok, code}: code 0 normal, 2 in-phase, 3 opposite, 4 reset view
  localparam logic [5:0] VEC [0:7] = '{
    {3'b011, 3'd0}, {3'b010, 3'd2}, {3'b001, 3'd3}, {3'b000, 3'd3},
    {3'b111, 3'd4}, {3'b110, 3'd4}, {3'b101, 3'd4}, {3'b100, 3'd4}
  };

  logic clk = 0, rst_n = 0, us_tick = 1, dstb_evt = 0, pstb_evt = 0, dstb_pin = 1;
  logic cmd_rst_slave = 0, cmd_rst_bcast = 0, sup5_ok = 0, sup24_ok = 0;
  logic overload = 0, fault_n = 1, addr_ok = 1;
  logic soft_rst_o, hard_rst_o, led1_o, led2_o;

  int n_chk = 0, n_err = 0, soft_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (soft_rst_o === 1'b1) soft_cnt++;

  comm_wdog_rstctl #(.WDOG_US(W), .RSTLOW_US(L), .BLINK_HALF_US(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .dstb_evt(dstb_evt), .pstb_evt(pstb_evt),
    .dstb_pin(dstb_pin), .cmd_rst_slave(cmd_rst_slave), .cmd_rst_bcast(cmd_rst_bcast),
    .sup5_ok(sup5_ok), .sup24_ok(sup24_ok), .overload(overload), .fault_n(fault_n),
    .addr_ok(addr_ok), .soft_rst_o(soft_rst_o), .hard_rst_o(hard_rst_o),
    .led1_o(led1_o), .led2_o(led2_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit on_data);
    @(negedge clk);
    if (on_data) dstb_evt = 1; else pstb_evt = 1;
    @(posedge clk);
    @(negedge clk);
    dstb_evt = 0; pstb_evt = 0;
  endtask

  task automatic pulse_cmd(input bit bcast);
    @(negedge clk);
    if (bcast) cmd_rst_bcast = 1; else cmd_rst_slave = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_rst_slave = 0; cmd_rst_bcast = 0;
  endtask

  // Cycles from one led2 change to the next, optional command in the middle.
  task automatic blink_gap(input bit with_cmd, output int n);
    logic p;
    @(negedge clk);
    p = led2_o;
    while (led2_o == p) @(negedge clk);
    p = led2_o;
    n = 0;
    while (led2_o == p) begin
      @(negedge clk);
      n++;
      if (with_cmd && n == H/2) begin
        cmd_rst_slave = 1;
        @(negedge clk);
        n++;
        cmd_rst_slave = 0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int s0, n;
    repeat (3) @(negedge clk);
    chk("R1 hard in reset", hard_rst_o, 1);
    chk("R5 no soft in reset", soft_rst_o, 0);
    rst_n = 1; sup5_ok = 1;
    repeat (5) @(negedge clk);
    chk("R1 hold until 24V", hard_rst_o, 1);
    sup24_ok = 1;
    @(posedge clk); @(negedge clk);
    chk("R1 release", hard_rst_o, 0);
    sup24_ok = 0;
    repeat (3) @(negedge clk);
    chk("R1 24V drop ignored", hard_rst_o, 0);
    sup24_ok = 1;
    chk("R8 normal pattern", {led1_o, led2_o}, 2'b01);

    // LED priority table
    for (int i = 0; i < 8; i++) begin
      int bad; bit s0a, s1a, s0b, s1b; int code;
      {overload, fault_n, addr_ok} = VEC[i][5:3];
      code = int'(VEC[i][2:0]);
      bad = 0; s0a = 0; s1a = 0; s0b = 0; s1b = 0;
      for (int c = 0; c < 2*H + 2; c++) begin
        @(negedge clk);
        if (led1_o) s1a = 1; else s0a = 1;
        if (led2_o) s1b = 1; else s0b = 1;
        case (code)
          0: if ({led1_o, led2_o} != 2'b01) bad++;
          2: if (led1_o != led2_o) bad++;
          3: if (led1_o == led2_o) bad++;
          default: if (led1_o != 1'b0) bad++;
        endcase
      end
      if (code == 2 || code == 3) begin if (!(s0a && s1a)) bad++; end
      if (code == 4) begin if (!(s0b && s1b)) bad++; end
      chk($sformatf("R8 vector %0d", i), bad, 0);
    end
    overload = 0; fault_n = 1; addr_ok = 1;

    // Blink half period
    overload = 1;
    blink_gap(0, n);
    chk("R9 blink half period", n, H);
    blink_gap(1, n);
    chk("R7 blink kept across soft reset", n, H);
    overload = 0;

    // Gap watchdog fires after W ticks
    strobe(0);
    s0 = soft_cnt;
    repeat (W-1) @(posedge clk);
    @(negedge clk);
    chk("R2 no fire before limit", soft_rst_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 fire at limit", soft_rst_o, 1);
    @(negedge clk);
    chk("R2 single-cycle pulse", soft_rst_o, 0);
    chk("R8 fired pattern", {led1_o, led2_o}, 2'b10);
    repeat (3*W) @(negedge clk);
    chk("R3 no rearm without strobe", soft_cnt - s0, 1);
    strobe(1);
    chk("R3 strobe clears fired", {led1_o, led2_o}, 2'b01);

    // Restart by a second strobe
    repeat (W-5) @(posedge clk);
    strobe(0);
    s0 = soft_cnt;
    repeat (W-1) @(posedge clk);
    @(negedge clk);
    chk("R3 restart delays fire", soft_cnt - s0, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 fire after restart", soft_rst_o, 1);

    // Tick gating
    strobe(1);
    s0 = soft_cnt;
    us_tick = 0;
    repeat (3*W) @(negedge clk);
    chk("R3 no advance without tick", soft_cnt - s0, 0);
    us_tick = 1;
    repeat (W+2) @(negedge clk);
    chk("R3 advances with tick", soft_cnt - s0, 1);

    // Commands
    pulse_cmd(0);
    chk("R5 slave command", soft_rst_o, 1);
    @(negedge clk);
    chk("R5 slave pulse width", soft_rst_o, 0);
    pulse_cmd(1);
    chk("R5 broadcast command", soft_rst_o, 1);

    // Soft reset during gap count
    strobe(0);
    repeat (10) @(posedge clk);
    pulse_cmd(0);
    chk("R7 command soft pulse", soft_rst_o, 1);
    repeat (W-12) @(posedge clk);
    @(negedge clk);
    chk("R7 count undisturbed early", soft_rst_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 count undisturbed fire", soft_rst_o, 1);

    // Pin held low
    repeat (3) @(negedge clk);
    s0 = soft_cnt;
    dstb_pin = 0;
    repeat (L/2) @(negedge clk);
    dstb_pin = 1;
    repeat (3) @(negedge clk);
    chk("R4 short low ignored", soft_cnt - s0, 0);
    dstb_pin = 0;
    repeat (L-1) @(posedge clk);
    @(negedge clk);
    chk("R4 no pulse before threshold", soft_rst_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R4 pulse at threshold", soft_rst_o, 1);
    chk("R8 held-low pattern", led1_o, 0);
    repeat (2*L) @(negedge clk);
    chk("R4 one pulse per low", soft_cnt - s0, 1);
    dstb_pin = 1;

    // Hard reset against watchdog
    strobe(0);
    repeat (W+2) @(negedge clk);
    chk("R6 fired before hard", {led1_o, led2_o}, 2'b10);
    strobe(1);
    repeat (10) @(negedge clk);
    s0 = soft_cnt;
    sup5_ok = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 hard on 5V loss", hard_rst_o, 1);
    cmd_rst_slave = 1;
    @(negedge clk);
    cmd_rst_slave = 0;
    chk("R6 no soft in hard", soft_rst_o, 0);
    sup5_ok = 1;
    repeat (3*W) @(negedge clk);
    chk("R6 watchdog disarmed by hard", soft_cnt - s0, 0);
    chk("R6 normal after hard", {led1_o, led2_o}, 2'b01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule